// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Detection

This block is the receive side of an asynchronous serial port. It oversamples one serial input line, assembles characters of eight data bits sent least significant bit first, and checks each one for parity, framing, overrun and break conditions. A 16-bit divisor input sets the bit rate. Each bit lasts eight sample ticks, and one tick occurs every divisor-plus-one clocks. Parity is optional and can be even or odd. Each frame has one stop bit.

Received characters leave on a valid/ready stream. A character is consumed in any cycle where `m_valid_o` and `m_ready_i` are both high. The serial wire cannot be paused, so back-pressure cannot stall reception. If a new character completes while the previous one is still held and is not being consumed in that cycle, the new one replaces the held one and the overrun flag is raised. Consuming a character clears the overrun, parity and framing flags together with `m_valid_o`. The break flag is separate: it stays high until the line returns high.

The serial input passes through a two-flop synchroniser before falling-edge detection. A start bit is accepted only if the line is still low at its middle sample. Otherwise the receiver returns to hunting for a start bit.

Top module: `serial_rx`

## Requirements
- R1: A sample tick occurs once every `baud_div_i`+1 clocks while a frame is in progress, and one bit spans 8 ticks. Any divisor from 0 to 65535 is accepted, and characters are received correctly at several divisor values.
- R2: The frame is one low start bit, then 8 data bits with the first bit on the wire placed in `m_data_o[0]`, then the optional parity bit, then the stop bit. Each bit is sampled at its middle tick. A completed character raises `m_valid_o`, and `m_data_o` stays stable until the character is consumed.
- R3: A falling edge followed by a line that is high again at the middle of the start bit is discarded. No character is delivered and the receiver returns to idle.
- R4: When `par_en_i` is 1, a parity bit follows data bit 7. With `par_odd_i`=0 the correct parity bit makes the total count of ones in the data bits plus the parity bit even. With `par_odd_i`=1 it makes that count odd. A mismatch sets `par_err_o` together with `m_valid_o`.
- R5: A stop bit sampled low sets `frm_err_o` and still delivers the character, unless the frame is a break.
- R6: A frame with every data bit, the parity bit (when enabled) and the stop bit all low is a break. It sets `brk_o` and does not deliver a character or set `frm_err_o`. `brk_o` clears once the synchronised line is high again, and reception then resumes.
- R7: A character that completes while `m_valid_o`=1 and `m_ready_i`=0 sets `ovr_err_o` and replaces the held data and flags.
- R8: A consuming handshake clears `m_valid_o`, `ovr_err_o`, `par_err_o` and `frm_err_o`. If a character completes in the same cycle as a handshake, the new character is held with `m_valid_o`=1 and `ovr_err_o`=0.
- R9: After reset `m_valid_o`, `par_err_o`, `frm_err_o`, `ovr_err_o` and `brk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| baud_div_i | input | 16 | Divisor: tick period is this value plus one clocks |
| par_en_i | input | 1 | 1 when a parity bit follows the data bits |
| par_odd_i | input | 1 | 0 selects even parity, 1 selects odd parity |
| m_valid_o | output | 1 | A received character is held |
| m_ready_i | input | 1 | Consumer accepts the held character |
| m_data_o | output | 8 | Received character |
| par_err_o | output | 1 | Held character failed its parity check |
| frm_err_o | output | 1 | Held character had a low stop bit |
| ovr_err_o | output | 1 | A character was overwritten before it was consumed |
| brk_o | output | 1 | Break seen; clears when the line goes high |

## Verification
Two events can land on the same clock edge: completion of a new character and a consumer handshake on the old one. The outcome of that edge decides whether overrun is reported. To provoke it, the bench first measures, at the ports, how many clocks pass from driving a start bit to `m_valid_o` rising. It then holds one character unconsumed, sends a second, and pulses `m_ready_i` exactly on the completion edge of the second. The pass condition is that the second character is held with `m_valid_o` high and `ovr_err_o` low. A companion case leaves `m_ready_i` low on that edge and expects overrun with the newer data.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic par_err;
    logic frm_err;
  } rx_flags_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rx_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rxd_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_o   = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || wrap)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          fall_i,
  input  logic          tick_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          run_o,
  output logic          done_o,
  output logic          brk_o,
  output logic [DW-1:0] data_o,
  output rx_flags_t     flags_o
);
  localparam int TW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int MID = OVS / 2 - 1;

  rx_state_e     state_q;
  logic [TW-1:0] t_q;
  logic [BW-1:0] bi_q;
  logic [DW-1:0] sh_q;
  logic          pbit_q, zero_q, done_q, brk_q;
  rx_flags_t     flags_q;
  logic          mid, eob, pe_calc;

  assign mid     = tick_i && (t_q == TW'(MID));
  assign eob     = tick_i && (t_q == TW'(OVS - 1));
  assign pe_calc = par_en_i && (pbit_q != ((^sh_q) ^ par_odd_i));
  assign run_o   = (state_q != ST_IDLE) && (state_q != ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
      bi_q    <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      zero_q  <= 1'b1;
      done_q  <= 1'b0;
      brk_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      done_q <= 1'b0;
      brk_q  <= 1'b0;
      if (tick_i) t_q <= eob ? '0 : t_q + TW'(1);
      case (state_q)
        ST_IDLE: begin
          t_q <= '0;
          if (fall_i) begin
            state_q <= ST_START;
            zero_q  <= 1'b1;
          end
        end
        ST_START: begin
          if (mid && rx_i) state_q <= ST_IDLE;
          else if (eob) begin
            state_q <= ST_DATA;
            bi_q    <= '0;
          end
        end
        ST_DATA: begin
          if (mid) begin
            sh_q   <= {rx_i, sh_q[DW-1:1]};
            zero_q <= zero_q & ~rx_i;
          end
          if (eob) begin
            if (bi_q == BW'(DW - 1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
            else                     bi_q    <= bi_q + BW'(1);
          end
        end
        ST_PAR: begin
          if (mid) begin
            pbit_q <= rx_i;
            zero_q <= zero_q & ~rx_i;
          end
          if (eob) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (mid) begin
            if (rx_i) begin
              done_q  <= 1'b1;
              flags_q <= '{par_err: pe_calc, frm_err: 1'b0};
              state_q <= ST_IDLE;
            end else if (zero_q) begin
              brk_q   <= 1'b1;
              state_q <= ST_HOLD;
            end else begin
              done_q  <= 1'b1;
              flags_q <= '{par_err: pe_calc, frm_err: 1'b1};
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign brk_o   = brk_q;
  assign data_o  = sh_q;
  assign flags_o = flags_q;

  // R6
  brk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !done_o);

  // R5
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || brk_o) |-> $past(run_o));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DW    = 8,
  parameter int OVS   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [DW-1:0]    m_data_o,
  output logic             par_err_o,
  output logic             frm_err_o,
  output logic             ovr_err_o,
  output logic             brk_o
);
  logic          rx_s, fall, tick, run, done, brk_pulse;
  logic [DW-1:0] fr_data;
  rx_flags_t     fr_flags;

  logic          valid_q, ovr_q, brk_q;
  logic [DW-1:0] data_q;
  rx_flags_t     flags_q;
  logic          rd;

  serial_rx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .rx_o   (rx_s),
    .fall_o (fall)
  );

  serial_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  serial_rx_frame #(.DW(DW), .OVS(OVS)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .fall_i    (fall),
    .tick_i    (tick),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .run_o     (run),
    .done_o    (done),
    .brk_o     (brk_pulse),
    .data_o    (fr_data),
    .flags_o   (fr_flags)
  );

  assign rd = valid_q & m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
    end else if (done) begin
      valid_q <= 1'b1;
      data_q  <= fr_data;
      flags_q <= fr_flags;
      ovr_q   <= valid_q & ~rd;
    end else if (rd) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      flags_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        brk_q <= 1'b0;
    else if (brk_pulse) brk_q <= 1'b1;
    else if (rx_s)      brk_q <= 1'b0;
  end

  assign m_valid_o = valid_q;
  assign m_data_o  = data_q;
  assign par_err_o = flags_q.par_err;
  assign frm_err_o = flags_q.frm_err;
  assign ovr_err_o = ovr_q;
  assign brk_o     = brk_q;

  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i && done) |=> (ovr_err_o && m_valid_o));

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i && !done) |=> (!m_valid_o && !ovr_err_o && !par_err_o && !frm_err_o));

  // R8
  read_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i && done) |=> (m_valid_o && !ovr_err_o));

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i && !done) |=> (m_valid_o && $stable(m_data_o)));
endmodule

// File: tb/serial_rx_tb_top.sv
module serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div_r = 16'd1;
  logic        pen = 1'b0;
  logic        podd = 1'b0;
  logic        m_ready = 1'b0;
  logic        m_valid;
  logic [7:0]  m_data;
  logic        pe, fe, ovr, brk;

  int total = 0;
  int bad = 0;
  int lat = 0;

  always #5 clk = ~clk;

  serial_rx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rxd_i      (rxd),
    .baud_div_i (div_r),
    .par_en_i   (pen),
    .par_odd_i  (podd),
    .m_valid_o  (m_valid),
    .m_ready_i  (m_ready),
    .m_data_o   (m_data),
    .par_err_o  (pe),
    .frm_err_o  (fe),
    .ovr_err_o  (ovr),
    .brk_o      (brk)
  );

  // snapshot {valid, data, pe, fe, ovr, brk}
  function automatic logic [12:0] snap();
    return {m_valid, m_data, pe, fe, ovr, brk};
  endfunction

  task automatic chk(input logic [12:0] exp, input string tag);
    total++;
    if (snap() !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, snap(), exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit pbad, input bit stop_v);
    int bt;
    bt = 8 * (int'(div_r) + 1);
    rxd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bt) @(negedge clk);
    end
    if (pen) begin
      rxd = (^b) ^ podd ^ pbad;
      repeat (bt) @(negedge clk);
    end
    rxd = stop_v;
    repeat (bt) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    repeat (n * 8 * (int'(div_r) + 1)) @(negedge clk);
  endtask

  task automatic read_pulse();
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk({1'b0, 8'h00, 4'b0000}, "R9 reset");

    // R1 R2 sweep, divisor 1, no parity
    div_r = 16'd1; pen = 1'b0;
    for (int i = 0; i < 256; i++) begin
      send(8'(i), 1'b0, 1'b1);
      idle_bits(1);
      chk({1'b1, 8'(i), 4'b0000}, "R2 sweep nopar");
      read_pulse();
      chk({1'b0, 8'(i), 4'b0000}, "R8 read clears");
    end

    // R4 even parity sweep, divisor 0, every fourth parity corrupted
    div_r = 16'd0; pen = 1'b1; podd = 1'b0;
    for (int i = 0; i < 256; i++) begin
      send(8'(i), (i % 4) == 3, 1'b1);
      idle_bits(1);
      chk({1'b1, 8'(i), (i % 4) == 3, 3'b000}, "R4 even parity");
      read_pulse();
    end

    // R4 odd parity, divisor 2
    div_r = 16'd2; podd = 1'b1;
    for (int i = 0; i < 64; i++) begin
      send(8'(i * 4 + 1), (i % 2) == 1, 1'b1);
      idle_bits(1);
      chk({1'b1, 8'(i * 4 + 1), (i % 2) == 1, 3'b000}, "R4 odd parity");
      read_pulse();
    end

    // R1 large divisor
    div_r = 16'd300; pen = 1'b0; podd = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    idle_bits(1);
    chk({1'b1, 8'hA5, 4'b0000}, "R1 divisor 300");
    read_pulse();

    // R3 glitch shorter than half a start bit
    div_r = 16'd3;
    rxd = 1'b0;
    repeat (2 * 4) @(negedge clk);
    idle_bits(2);
    chk({1'b0, 8'hA5, 4'b0000}, "R3 glitch ignored");
    send(8'h96, 1'b0, 1'b1);
    idle_bits(1);
    chk({1'b1, 8'h96, 4'b0000}, "R3 recovery after glitch");
    read_pulse();

    // R5 framing error
    div_r = 16'd1;
    send(8'h3C, 1'b0, 1'b0);
    idle_bits(1);
    chk({1'b1, 8'h3C, 4'b0100}, "R5 framing");
    read_pulse();
    chk({1'b0, 8'h3C, 4'b0000}, "R8 framing cleared");

    // R6 break without parity
    send(8'h00, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    chk({1'b0, 8'h3C, 4'b0001}, "R6 break flagged");
    idle_bits(1);
    chk({1'b0, 8'h3C, 4'b0000}, "R6 break cleared");

    // R6 break with even parity, then recovery
    pen = 1'b1;
    send(8'h00, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    chk({1'b0, 8'h3C, 4'b0001}, "R6 break with parity");
    idle_bits(1);
    send(8'h81, 1'b0, 1'b1);
    idle_bits(1);
    chk({1'b1, 8'h81, 4'b0000}, "R6 resume after break");
    read_pulse();
    pen = 1'b0;

    // R7 overrun
    send(8'h44, 1'b0, 1'b1);
    idle_bits(1);
    send(8'h55, 1'b0, 1'b1);
    idle_bits(1);
    chk({1'b1, 8'h55, 4'b0010}, "R7 overrun");
    read_pulse();
    chk({1'b0, 8'h55, 4'b0000}, "R8 overrun cleared");

    // R8 measure start-to-valid latency at the ports
    fork
      send(8'h11, 1'b0, 1'b1);
      begin
        lat = 0;
        while (!m_valid) begin
          @(negedge clk);
          lat++;
        end
      end
    join
    idle_bits(1);
    read_pulse();

    // R8 handshake on the completion edge of a new character
    send(8'h22, 1'b0, 1'b1);
    idle_bits(1);
    fork
      send(8'h33, 1'b0, 1'b1);
      begin
        repeat (lat - 1) @(negedge clk);
        m_ready = 1'b1;
        @(negedge clk);
        m_ready = 1'b0;
      end
    join
    idle_bits(1);
    chk({1'b1, 8'h33, 4'b0000}, "R8 read on completion edge");
    read_pulse();
    chk({1'b0, 8'h33, 4'b0000}, "R8 final read");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule